// File: doc/BRIEF.md
# SD Single-Line Data Block Receiver

This block takes one data block from a memory card on a single DAT line. Software arms it by pulsing a start request, which sets an internal enable bit that the block reports as `busy`. The receiver then hunts for a low start bit, shifts in the payload most significant bit first, collects the 16 check bits that follow, and samples the closing end bit. Each completed byte is handed to a downstream consumer through a one-entry holding register with a valid/ready handshake.

When the end bit has been sampled, the enable bit drops by itself. A sticky completion flag is raised, along with a CRC failure flag when the locally computed CRC-16 (polynomial x^16+x^12+x^5+1, initial value zero, payload bits only) differs from the received check field, and a framing flag when the end bit is low. All three flags are write-1-to-clear. The interrupt output is the completion flag gated by an interrupt enable input.

Card bits are qualified by a one-cycle sample strobe, so the block runs on the system clock and does not depend on the card clock frequency.

Top module: `sd_blk_rx`

## Requirements
- R1: One clock after `go_set` is sampled high, `busy` is 1. It stays 1 until the end bit has been sampled and is 0 the cycle after that strobe (unless `go_set` is high in that same cycle). A `go_set` pulse while `busy` is 1 has no effect.
- R2: Strobes are ignored while `busy` is 0. While `busy` is 1, strobes with `card_dat`=1 are ignored before the block starts. The first strobe with `card_dat`=0 is taken as the start bit.
- R3: The next `BLK_BYTES`*8 strobed bits form the payload, most significant bit first. Each byte appears on `m_data` with `m_valid`=1 one cycle after the strobe of its eighth bit. It is held unchanged until a cycle with `m_ready`=1.
- R4: `sts[1]` (CRC failure) is set one cycle after the end-bit strobe when the 16 strobed check bits (MSB first) differ from the CRC-16 of the payload (polynomial 0x1021, initial value 0). When they match, the bit is left unchanged.
- R5: `sts[2]` (framing error) is set one cycle after the end-bit strobe when `card_dat` is 0 on that strobe.
- R6: `sts[0]` (done) is set one cycle after every end-bit strobe.
- R7: For each status bit, a 1 in `sts_clr` clears that bit on the next edge. If the bit is set and cleared in the same cycle, the set wins.
- R8: `irq` equals `sts[0]` AND `irq_en` at all times, with no register between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_set | input | 1 | Request to arm the receiver (sets the enable bit) |
| irq_en | input | 1 | Completion interrupt enable |
| sts_clr | input | 3 | Write-1-to-clear strobes for the status bits |
| card_stb | input | 1 | One-cycle strobe marking a valid DAT sample |
| card_dat | input | 1 | Serial DAT line from the card |
| m_ready | input | 1 | Downstream ready for the byte stream |
| m_valid | output | 1 | Byte stream valid |
| m_data | output | 8 | Received byte |
| busy | output | 1 | Enable bit; clears itself at the end of the block |
| sts | output | 3 | Status: bit0 done, bit1 CRC failure, bit2 framing error |
| irq | output | 1 | Completion interrupt |

## Verification
The status flags can be set by the end of a block in the same cycle that software writes 1 to clear them. The bench provokes this by driving all ones on `sts_clr` in the exact cycle of the end-bit strobe. A stale CRC failure flag from an earlier block is cleared, while the new done and framing flags must survive. A behavioural model updated on every edge gives the expected status word, `busy`, `irq` and byte stream. These are compared each cycle, including while `m_ready` is throttled between bytes.

// File: rtl/sdrx_pkg.sv
package sdrx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HUNT,
      ST_PAYLOAD,
      ST_CHECK,
      ST_STOP
   } rx_state_t;

   localparam int STS_DONE  = 0;
   localparam int STS_CRC   = 1;
   localparam int STS_FRAME = 2;
   localparam int STS_W     = 3;
endpackage

// File: rtl/sdrx_crc_ser.sv
module sdrx_crc_ser #(
   parameter int             CRC_W = 16,
   parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             shift,
   input  logic             din,
   output logic [CRC_W-1:0] crc
);
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_d;
   logic             fb;

   assign fb       = crc_q[CRC_W-1] ^ din;
   assign crc_d[0] = fb & POLY[0];

   for (genvar i = 1; i < CRC_W; i++) begin : g_tap
      if (POLY[i]) begin : g_xor
         assign crc_d[i] = crc_q[i-1] ^ fb;
      end else begin : g_pass
         assign crc_d[i] = crc_q[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc_q <= '0;
      else if (clear) crc_q <= '0;
      else if (shift) crc_q <= crc_d;
   end

   assign crc = crc_q;
endmodule

// File: rtl/sdrx_seq.sv
module sdrx_seq
   import sdrx_pkg::*;
#(
   parameter int BLK_BYTES = 512,
   parameter int CRC_W     = 16,
   parameter int DW        = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             stb,
   input  logic             dat,
   output logic             start_hit,
   output logic             pay_bit,
   output logic             byte_push,
   output logic [DW-1:0]    byte_val,
   output logic [CRC_W-1:0] rx_crc,
   output logic             fin,
   output logic             end_ok
);
   localparam int PAY_BITS = BLK_BYTES * DW;
   localparam int CNT_W    = $clog2(PAY_BITS + 1);
   localparam int LOG_DW   = $clog2(DW);

   rx_state_t        state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [DW-2:0]    shreg_q;
   logic [CRC_W-1:0] rx_crc_q;

   assign start_hit = (state_q == ST_HUNT) && stb && !dat;
   assign pay_bit   = (state_q == ST_PAYLOAD) && stb;
   assign byte_val  = {shreg_q, dat};
   assign byte_push = pay_bit && (&cnt_q[LOG_DW-1:0]);
   assign fin       = (state_q == ST_STOP) && stb;
   assign end_ok    = dat;
   assign rx_crc    = rx_crc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cnt_q    <= '0;
         shreg_q  <= '0;
         rx_crc_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (en) state_q <= ST_HUNT;
            ST_HUNT: if (start_hit) begin
               state_q <= ST_PAYLOAD;
               cnt_q   <= '0;
            end
            ST_PAYLOAD: if (stb) begin
               shreg_q <= byte_val[DW-2:0];
               if (cnt_q == CNT_W'(PAY_BITS - 1)) begin
                  state_q <= ST_CHECK;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_CHECK: if (stb) begin
               rx_crc_q <= {rx_crc_q[CRC_W-2:0], dat};
               if (cnt_q == CNT_W'(CRC_W - 1)) begin
                  state_q <= ST_STOP;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_STOP: if (stb) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sdrx_byte_hold.sv
module sdrx_byte_hold #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   output logic          m_valid,
   output logic [DW-1:0] m_data,
   input  logic          m_ready
);
   logic          vld_q;
   logic [DW-1:0] dat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         dat_q <= '0;
      end else if (push) begin
         vld_q <= 1'b1;
         dat_q <= push_data;
      end else if (m_ready) begin
         vld_q <= 1'b0;
      end
   end

   assign m_valid = vld_q;
   assign m_data  = dat_q;
endmodule

// File: rtl/sdrx_status.sv
module sdrx_status #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_v,
   input  logic [W-1:0] clr_v,
   output logic [W-1:0] q
);
   for (genvar b = 0; b < W; b++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        bit_q <= 1'b0;
         else if (set_v[b]) bit_q <= 1'b1;
         else if (clr_v[b]) bit_q <= 1'b0;
      end
      assign q[b] = bit_q;
   end
endmodule

// File: rtl/sd_blk_rx.sv
module sd_blk_rx
   import sdrx_pkg::*;
#(
   parameter int             BLK_BYTES = 512,
   parameter int             DW        = 8,
   parameter int             CRC_W     = 16,
   parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_set,
   input  logic             irq_en,
   input  logic [STS_W-1:0] sts_clr,
   input  logic             card_stb,
   input  logic             card_dat,
   input  logic             m_ready,
   output logic             m_valid,
   output logic [DW-1:0]    m_data,
   output logic             busy,
   output logic [STS_W-1:0] sts,
   output logic             irq
);
   if (DW < 2 || DW != (1 << $clog2(DW))) begin : g_bad_dw
      $error("sd_blk_rx: DW must be a power of two of at least 2");
   end
   if (BLK_BYTES < 1 || BLK_BYTES * DW < CRC_W) begin : g_bad_blk
      $error("sd_blk_rx: block must hold at least CRC_W bits");
   end
   if (CRC_W < 2) begin : g_bad_crc
      $error("sd_blk_rx: CRC_W must be at least 2");
   end

   logic             en_q;
   logic             start_hit;
   logic             pay_bit;
   logic             byte_push;
   logic [DW-1:0]    byte_val;
   logic [CRC_W-1:0] rx_crc;
   logic [CRC_W-1:0] calc_crc;
   logic             fin;
   logic             end_ok;
   logic [STS_W-1:0] sts_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= go_set | (en_q & ~fin);
   end

   sdrx_seq #(
      .BLK_BYTES(BLK_BYTES),
      .CRC_W    (CRC_W),
      .DW       (DW)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_q),
      .stb      (card_stb),
      .dat      (card_dat),
      .start_hit(start_hit),
      .pay_bit  (pay_bit),
      .byte_push(byte_push),
      .byte_val (byte_val),
      .rx_crc   (rx_crc),
      .fin      (fin),
      .end_ok   (end_ok)
   );

   sdrx_crc_ser #(
      .CRC_W(CRC_W),
      .POLY (CRC_POLY)
   ) u_crc (
      .clk  (clk),
      .rst_n(rst_n),
      .clear(start_hit),
      .shift(pay_bit),
      .din  (card_dat),
      .crc  (calc_crc)
   );

   sdrx_byte_hold #(
      .DW(DW)
   ) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (byte_push),
      .push_data(byte_val),
      .m_valid  (m_valid),
      .m_data   (m_data),
      .m_ready  (m_ready)
   );

   always_comb begin
      sts_set            = '0;
      sts_set[STS_DONE]  = fin;
      sts_set[STS_CRC]   = fin && (rx_crc != calc_crc);
      sts_set[STS_FRAME] = fin && !end_ok;
   end

   sdrx_status #(
      .W(STS_W)
   ) u_sts (
      .clk  (clk),
      .rst_n(rst_n),
      .set_v(sts_set),
      .clr_v(sts_clr),
      .q    (sts)
   );

   assign busy = en_q;
   assign irq  = sts[STS_DONE] & irq_en;
endmodule

// File: rtl/sd_blk_rx_chk.sv
module sd_blk_rx_chk
   import sdrx_pkg::*;
#(
   parameter int DW = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             go_set,
   input logic             irq_en,
   input logic             m_valid,
   input logic             m_ready,
   input logic [DW-1:0]    m_data,
   input logic             busy,
   input logic [STS_W-1:0] sts,
   input logic             irq
);
   AST_GO_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      go_set |=> busy); // R1

   AST_IDLE_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> !$rose(m_valid)); // R2

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_data))); // R3

   AST_CRC_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts[STS_CRC]) |-> sts[STS_DONE]); // R4

   AST_FRAME_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts[STS_FRAME]) |-> sts[STS_DONE]); // R5

   AST_END_MARKS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> sts[STS_DONE]); // R6

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> irq_en); // R8
endmodule

bind sd_blk_rx sd_blk_rx_chk #(.DW(DW)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .go_set (go_set),
   .irq_en (irq_en),
   .m_valid(m_valid),
   .m_ready(m_ready),
   .m_data (m_data),
   .busy   (busy),
   .sts    (sts),
   .irq    (irq)
);

// File: tb/sd_blk_rx_tb.sv
module sd_blk_rx_tb;
   localparam int BYTES = 512;
   localparam int BITS  = BYTES * 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       go_set = 1'b0;
   logic       irq_en = 1'b0;
   logic [2:0] sts_clr = 3'b000;
   logic       card_stb = 1'b0;
   logic       card_dat = 1'b1;
   logic       m_ready = 1'b1;
   logic       m_valid;
   logic [7:0] m_data;
   logic       busy;
   logic [2:0] sts;
   logic       irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit throttle = 1'b0;
   int cyc = 0;

   always #5 clk = ~clk;

   sd_blk_rx u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .go_set  (go_set),
      .irq_en  (irq_en),
      .sts_clr (sts_clr),
      .card_stb(card_stb),
      .card_dat(card_dat),
      .m_ready (m_ready),
      .m_valid (m_valid),
      .m_data  (m_data),
      .busy    (busy),
      .sts     (sts),
      .irq     (irq)
   );

   function automatic logic [15:0] crc16_q(input logic [7:0] q[$]);
      logic [15:0] c = 16'h0000;
      foreach (q[i]) begin
         for (int b = 7; b >= 0; b--) begin
            logic fb = c[15] ^ q[i][b];
            c = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
         end
      end
      return c;
   endfunction

   // ---------------- behavioural reference model ----------------
   logic       e_busy, e_valid;
   logic [7:0] e_data, cur;
   logic [2:0] e_sts, setv;
   logic [15:0] rcrc;
   logic        fin_now;
   int          ph, nbits;
   logic [7:0]  mq[$];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_busy = 0; e_valid = 0; e_data = 0; e_sts = 0;
         ph = 0; nbits = 0; cur = 0; rcrc = 0;
         mq.delete();
      end else begin
         fin_now = 0;
         setv    = 3'b000;
         if (e_valid && m_ready) e_valid = 0;
         case (ph)
            0: if (e_busy) ph = 1;
            1: if (card_stb && !card_dat) begin
               ph = 2; nbits = 0; mq.delete();
            end
            2: if (card_stb) begin
               cur = {cur[6:0], card_dat};
               nbits++;
               if (nbits % 8 == 0) begin
                  e_valid = 1; e_data = cur; mq.push_back(cur);
               end
               if (nbits == BITS) begin
                  ph = 3; nbits = 0; rcrc = 0;
               end
            end
            3: if (card_stb) begin
               rcrc = {rcrc[14:0], card_dat};
               nbits++;
               if (nbits == 16) ph = 4;
            end
            4: if (card_stb) begin
               fin_now = 1;
               setv = {~card_dat, (rcrc != crc16_q(mq)), 1'b1};
               ph = 0;
            end
            default: ph = 0;
         endcase
         e_sts  = (e_sts & ~sts_clr) | setv;
         e_busy = go_set | (e_busy & ~fin_now);
      end
   end

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         chk("R1 busy", {7'b0, busy}, {7'b0, e_busy});
         chk("R3 m_valid", {7'b0, m_valid}, {7'b0, e_valid});
         if (e_valid) chk("R3 m_data", m_data, e_data);
         chk("R6 sts done", {7'b0, sts[0]}, {7'b0, e_sts[0]});
         chk("R4 sts crc", {7'b0, sts[1]}, {7'b0, e_sts[1]});
         chk("R5 sts frame", {7'b0, sts[2]}, {7'b0, e_sts[2]});
         chk("R8 irq", {7'b0, irq}, {7'b0, e_sts[0] & irq_en});
      end
   end

   // ready throttling: low 3 cycles in 7 when enabled (R3 backpressure)
   always @(negedge clk) begin
      #1;
      m_ready = throttle ? ((cyc % 7) >= 3) : 1'b1;
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_out(input logic b);
      @(negedge clk); #1;
      card_dat = b; card_stb = 1'b1;
      @(negedge clk); #1;
      card_stb = 1'b0; card_dat = 1'b1;
   endtask

   task automatic pulse_go();
      @(negedge clk); #1; go_set = 1'b1;
      @(negedge clk); #1; go_set = 1'b0;
   endtask

   task automatic send_block(input int seed, input bit bad_crc, input bit bad_end,
                             input bit clr_at_end);
      logic [7:0]  pay[$];
      logic [15:0] c;
      for (int i = 0; i < BYTES; i++) pay.push_back(8'((i * seed + seed * 3) ^ (i >> 3)));
      c = crc16_q(pay);
      if (bad_crc) c = c ^ 16'h0100;
      bit_out(1'b0);                           // start bit (R2)
      foreach (pay[i]) begin
         for (int b = 7; b >= 0; b--) bit_out(pay[i][b]);
         if (i == 100) pulse_go();             // R1: go while busy is ignored
      end
      for (int b = 15; b >= 0; b--) bit_out(c[b]);
      @(negedge clk); #1;
      card_dat = ~bad_end; card_stb = 1'b1;
      if (clr_at_end) sts_clr = 3'b111;        // R7 collision with completion
      @(negedge clk); #1;
      card_stb = 1'b0; card_dat = 1'b1; sts_clr = 3'b000;
   endtask

   task automatic clear_sts(input logic [2:0] m);
      @(negedge clk); #1; sts_clr = m;
      @(negedge clk); #1; sts_clr = 3'b000;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      idle(3);
      @(negedge clk); #1; rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset busy", {7'b0, busy}, 8'h00);
      chk("R6 reset sts", {5'b0, sts}, 8'h00);
      chk("R3 reset m_valid", {7'b0, m_valid}, 8'h00);

      // R2: strobes with a low line while not armed are ignored
      for (int k = 0; k < 12; k++) bit_out(1'b0);
      idle(2);
      chk("R2 idle strobes no byte", {7'b0, m_valid}, 8'h00);

      // Block 1: good CRC and end bit, interrupt enabled, idle-high strobes first
      irq_en = 1'b1;
      pulse_go();
      idle(2);
      for (int k = 0; k < 5; k++) bit_out(1'b1);   // R2: high strobes before start
      send_block(37, 1'b0, 1'b0, 1'b0);
      idle(3);
      chk("R6 done after block1", {5'b0, sts}, 8'h01);
      chk("R8 irq after block1", {7'b0, irq}, 8'h01);
      chk("R1 busy cleared block1", {7'b0, busy}, 8'h00);
      @(negedge clk); #1; irq_en = 1'b0;
      idle(1);
      chk("R8 irq masked", {7'b0, irq}, 8'h00);
      clear_sts(3'b001);
      idle(1);
      chk("R7 done cleared", {5'b0, sts}, 8'h00);

      // Block 2: corrupted CRC, throttled consumer
      throttle = 1'b1;
      pulse_go();
      idle(3);
      send_block(11, 1'b1, 1'b0, 1'b0);
      idle(3);
      chk("R4 crc failure flagged", {5'b0, sts}, 8'h03);
      throttle = 1'b0;

      // Block 3: bad end bit, clear-all in the end cycle, interrupt on
      irq_en = 1'b1;
      pulse_go();
      idle(3);
      send_block(5, 1'b0, 1'b1, 1'b1);
      idle(3);
      chk("R7 set wins over clear", {5'b0, sts}, 8'h05);
      chk("R5 frame flagged", {7'b0, sts[2]}, 8'h01);
      chk("R8 irq block3", {7'b0, irq}, 8'h01);
      clear_sts(3'b110);
      idle(1);
      chk("R7 partial clear", {5'b0, sts}, 8'h01);

      idle(4);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule